// File: doc/BRIEF.md
# Register Rename History Buffer

This block keeps, for one hardware thread, an ordered log of every destination-register rename made by the rename stage. Each log entry records the instruction's sequence number, the architectural register that was renamed, the physical register just assigned to it, and the physical register it was mapped to before the rename. Only instructions that write a destination register make entries, one entry for each destination renamed.

The log is used in two directions. When the retire logic reports a committed sequence number, entries are taken from the oldest end and their earlier physical registers are handed back to the free list, because no instruction can still read them. When the recovery logic reports a squash, entries younger than the squash point are undone from the youngest end. Each undo writes the earlier mapping back into the map table and returns the never-committed new register to the free list. Storage is a circular array. The rename stage must stall while `full` is high, and pushes offered during a squash are dropped.

Top module: `rename_history_buf`

## Requirements
- R1: While reset is held low at a clock edge, the block afterwards shows `empty`=1, `full`=0, `busy`=0, `restore_valid`=0, `release_valid`=0 and both mapping counters at zero.
- R2: A push is stored when `push_valid` is high, `full` is low, `squash_valid` is low and `busy` is low. `full` rises once DEPTH entries are held, and a push offered while `full` is high adds no entry.
- R3: In each cycle after a squash request, one entry is undone, youngest first, while the youngest entry is younger than the squash sequence number. An undo drives `restore_valid`=1 with `restore_areg`/`restore_preg` set to the entry's architectural register and previous physical register. In the same cycle it drives `release_valid`=1 with `release_preg` set to the entry's new physical register.
- R4: `busy` is high exactly in the cycles that perform an undo. The walk stops at the first entry that is not younger than the squash point, and that entry and all older ones are kept.
- R5: From the cycle after a commit request, one entry per cycle is removed from the oldest end while its sequence number is not younger than the committed sequence number. Each removal drives `release_valid`=1 with `release_preg` set to the entry's previous physical register and `restore_valid`=0.
- R6: Squash has priority over commit. In a cycle with `squash_valid` high, or with `busy` high, no commit removal happens. A commit request that arrives with a squash is kept, and its removals run once the undo walk ends.
- R7: `committed_maps` increases by one for every commit removal and `undone_maps` increases by one for every undo. Each counter wraps at 2^CNT_W.
- R8: Pushes offered in the cycle of `squash_valid`, or during an undo walk, are dropped.
- R9: `empty` is high exactly when the buffer holds no entries.
- R10: Sequence numbers are compared modulo 2^SEQ_W. Sequence a is younger than b when (a-b) mod 2^SEQ_W lies in 1 to 2^(SEQ_W-1)-1, so ordering holds across the wrap from the largest value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Rename stage offers a new entry |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Physical register newly assigned |
| push_old_preg | input | PREG_W | Physical register mapped before the rename |
| commit_valid | input | 1 | Retire logic reports a committed sequence number |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Recovery logic requests a squash |
| squash_seq | input | SEQ_W | Squash point; younger entries are undone |
| restore_valid | output | 1 | Write to the map table this cycle |
| restore_areg | output | AREG_W | Map table index to restore |
| restore_preg | output | PREG_W | Physical register to write back |
| release_valid | output | 1 | Return a register to the free list this cycle |
| release_preg | output | PREG_W | Register being returned |
| busy | output | 1 | Undo walk is removing an entry this cycle |
| full | output | 1 | Buffer holds DEPTH entries; rename must stall |
| empty | output | 1 | Buffer holds no entries |
| committed_maps | output | CNT_W | Running count of committed mappings |
| undone_maps | output | CNT_W | Running count of mappings undone by squash |

## Verification
A wrong head or tail pointer, or a stale full flag, shows up during the next walk. The release or restore values come from the wrong entry, or the walk undoes one entry too many or too few, and `busy` or `empty` disagrees with the expected occupancy. The bench sweeps every fill level from zero to DEPTH against every squash point, then commits the survivors. A single bad entry is therefore visible within DEPTH+2 cycles of the walk that reaches it. The sequence numbers cross the wrap, so a comparison that ignores the modulus fails in the sweep. The priority case, with squash and commit in the same cycle, shows whether a commit removal leaked into the undo walk.

// File: rtl/rhb_pkg.sv
// Package: shared types and the sequence-order helper for the rename
// history buffer. Assumes sequence widths of at most 32 bits.
package rhb_pkg;

    // Source of the free-list write in a given cycle.
    typedef enum logic [1:0] {
        REL_NONE   = 2'd0,
        REL_UNDO   = 2'd1,
        REL_RETIRE = 2'd2
    } rel_src_e;

    // True when sequence a is strictly younger than b, modulo 2^w.
    function automatic logic seq_younger(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input int unsigned w);
        logic [31:0] mask;
        logic [31:0] diff;
        mask = (w >= 32) ? '1 : ((32'h1 << w) - 32'h1);
        diff = (a - b) & mask;
        return (diff != '0) && !diff[5'(w - 1)];
    endfunction

endpackage

// File: rtl/rhb_store.sv
// Module: circular entry storage with head (oldest) and tail (next free)
// pointers and a full flag. Assumes DEPTH is a power of two, at least 2,
// and that push and pop_tail never arrive in the same cycle.
module rhb_store #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 8,
    parameter int AREG_W = 5,
    parameter int PREG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [AREG_W-1:0] in_areg,
    input  logic [PREG_W-1:0] in_newp,
    input  logic [PREG_W-1:0] in_oldp,
    input  logic              pop_head,
    input  logic              pop_tail,
    output logic [SEQ_W-1:0]  head_seq,
    output logic [PREG_W-1:0] head_oldp,
    output logic [SEQ_W-1:0]  tail_seq,
    output logic [AREG_W-1:0] tail_areg,
    output logic [PREG_W-1:0] tail_newp,
    output logic [PREG_W-1:0] tail_oldp,
    output logic              empty,
    output logic              full
);
    localparam int PW = $clog2(DEPTH);
    localparam int EW = SEQ_W + AREG_W + 2 * PREG_W;
    localparam int OLD_LSB  = 0;
    localparam int NEW_LSB  = PREG_W;
    localparam int AREG_LSB = 2 * PREG_W;
    localparam int SEQ_LSB  = 2 * PREG_W + AREG_W;

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [PW-1:0] last_q;
    logic          full_q;
    logic [EW-1:0] head_ent;
    logic [EW-1:0] tail_ent;

    // Write a new entry at the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[tail_q] <= {in_seq, in_areg, in_newp, in_oldp};
        end
    end

    // Advance the head on commit removal, move the tail on push or undo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (pop_head) head_q <= head_q + PW'(1);
            if (push)          tail_q <= tail_q + PW'(1);
            else if (pop_tail) tail_q <= tail_q - PW'(1);
        end
    end

    // Track the full condition, which pointer equality alone cannot tell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (pop_head || pop_tail) begin
            full_q <= 1'b0;
        end else if (push && ((tail_q + PW'(1)) == head_q)) begin
            full_q <= 1'b1;
        end
    end

    // Read out the oldest and youngest entries.
    always_comb begin
        last_q   = tail_q - PW'(1);
        head_ent = mem[head_q];
        tail_ent = mem[last_q];
    end

    assign head_seq  = head_ent[SEQ_LSB +: SEQ_W];
    assign head_oldp = head_ent[OLD_LSB +: PREG_W];
    assign tail_seq  = tail_ent[SEQ_LSB +: SEQ_W];
    assign tail_areg = tail_ent[AREG_LSB +: AREG_W];
    assign tail_newp = tail_ent[NEW_LSB +: PREG_W];
    assign tail_oldp = tail_ent[OLD_LSB +: PREG_W];
    assign full      = full_q;
    assign empty     = !full_q && (head_q == tail_q);

endmodule

// File: rtl/rhb_ctrl.sv
// Module: sequencing for the undo walk (youngest first) and the commit
// removal walk (oldest first), plus push admission. Squash has priority.
// Assumes the squash and commit bounds stay within half the sequence space
// of the stored entries.
module rhb_ctrl #(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             push_valid,
    input  logic             empty,
    input  logic             full,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic [SEQ_W-1:0] tail_seq,
    output logic             pop_head,
    output logic             pop_tail,
    output logic             push_ok
);
    import rhb_pkg::*;

    logic             sq_active;
    logic [SEQ_W-1:0] sq_bound;
    logic             cm_active;
    logic [SEQ_W-1:0] cm_bound;
    logic             undo_pend;
    logic             retire_pend;
    logic             keep_sq;
    logic             keep_cm;

    // Decide which walk removes an entry this cycle.
    always_comb begin
        undo_pend   = sq_active && !empty &&
                      seq_younger(32'(tail_seq), 32'(sq_bound), SEQ_W);
        retire_pend = cm_active && !empty && !squash_valid && !undo_pend &&
                      !seq_younger(32'(head_seq), 32'(cm_bound), SEQ_W);
        keep_sq     = sq_active &&
                      seq_younger(32'(squash_seq), 32'(sq_bound), SEQ_W);
        keep_cm     = cm_active &&
                      seq_younger(32'(cm_bound), 32'(commit_seq), SEQ_W);
    end

    // Hold the squash bound, keeping the older one if two squashes overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_active <= 1'b0;
            sq_bound  <= '0;
        end else if (squash_valid) begin
            sq_active <= 1'b1;
            if (!keep_sq) sq_bound <= squash_seq;
        end else if (!undo_pend) begin
            sq_active <= 1'b0;
        end
    end

    // Hold the commit bound, only ever moving it younger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_active <= 1'b0;
            cm_bound  <= '0;
        end else if (commit_valid) begin
            cm_active <= 1'b1;
            if (!keep_cm) cm_bound <= commit_seq;
        end
    end

    assign pop_tail = undo_pend;
    assign pop_head = retire_pend;
    assign push_ok  = push_valid && !full && !squash_valid && !undo_pend;

endmodule

// File: rtl/rhb_tally.sv
// Module: two wrapping event counters, slot 0 for committed mappings and
// slot 1 for undone mappings.
module rhb_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_commit,
    input  logic             inc_undo,
    output logic [CNT_W-1:0] commit_cnt,
    output logic [CNT_W-1:0] undo_cnt
);
    localparam int NCNT = 2;

    logic [NCNT-1:0]  inc;
    logic [CNT_W-1:0] cnt [NCNT];

    assign inc = {inc_undo, inc_commit};

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        // Count one event per cycle on this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt[g] <= '0;
            else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
        end
    end

    assign commit_cnt = cnt[0];
    assign undo_cnt   = cnt[1];

endmodule

// File: rtl/rename_history_buf.sv
// Module: register rename history buffer for one thread. Logs each
// destination rename, undoes younger mappings on squash (map restore plus
// free-list return of the new register) and frees previous registers on
// commit. Assumes DEPTH is a power of two and SEQ_W <= 32.
module rename_history_buf #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 8,
    parameter int AREG_W = 5,
    parameter int PREG_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new_preg,
    input  logic [PREG_W-1:0] push_old_preg,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              restore_valid,
    output logic [AREG_W-1:0] restore_areg,
    output logic [PREG_W-1:0] restore_preg,
    output logic              release_valid,
    output logic [PREG_W-1:0] release_preg,
    output logic              busy,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  committed_maps,
    output logic [CNT_W-1:0]  undone_maps
);
    import rhb_pkg::*;

    logic              push_ok;
    logic              pop_head;
    logic              pop_tail;
    logic [SEQ_W-1:0]  head_seq;
    logic [PREG_W-1:0] head_oldp;
    logic [SEQ_W-1:0]  tail_seq;
    logic [AREG_W-1:0] tail_areg;
    logic [PREG_W-1:0] tail_newp;
    logic [PREG_W-1:0] tail_oldp;
    rel_src_e          rel_src;

    rhb_store #(
        .DEPTH (DEPTH),
        .SEQ_W (SEQ_W),
        .AREG_W(AREG_W),
        .PREG_W(PREG_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_ok),
        .in_seq   (push_seq),
        .in_areg  (push_areg),
        .in_newp  (push_new_preg),
        .in_oldp  (push_old_preg),
        .pop_head (pop_head),
        .pop_tail (pop_tail),
        .head_seq (head_seq),
        .head_oldp(head_oldp),
        .tail_seq (tail_seq),
        .tail_areg(tail_areg),
        .tail_newp(tail_newp),
        .tail_oldp(tail_oldp),
        .empty    (empty),
        .full     (full)
    );

    rhb_ctrl #(
        .SEQ_W(SEQ_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .squash_valid(squash_valid),
        .squash_seq  (squash_seq),
        .commit_valid(commit_valid),
        .commit_seq  (commit_seq),
        .push_valid  (push_valid),
        .empty       (empty),
        .full        (full),
        .head_seq    (head_seq),
        .tail_seq    (tail_seq),
        .pop_head    (pop_head),
        .pop_tail    (pop_tail),
        .push_ok     (push_ok)
    );

    rhb_tally #(
        .CNT_W(CNT_W)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_commit(pop_head),
        .inc_undo  (pop_tail),
        .commit_cnt(committed_maps),
        .undo_cnt  (undone_maps)
    );

    // Pick which walk owns the free-list port this cycle.
    always_comb begin
        if (pop_tail)      rel_src = REL_UNDO;
        else if (pop_head) rel_src = REL_RETIRE;
        else               rel_src = REL_NONE;
    end

    // Steer the free-list write from the selected entry.
    always_comb begin
        release_valid = 1'b0;
        release_preg  = '0;
        case (rel_src)
            REL_UNDO: begin
                release_valid = 1'b1;
                release_preg  = tail_newp;
            end
            REL_RETIRE: begin
                release_valid = 1'b1;
                release_preg  = head_oldp;
            end
            default: ;
        endcase
    end

    assign restore_valid = pop_tail;
    assign restore_areg  = tail_areg;
    assign restore_preg  = tail_oldp;
    assign busy          = pop_tail;

endmodule

// File: rtl/rhb_checker.sv
// Module: temporal checks on the rename history buffer ports, attached to
// every instance of the top module by the bind below.
module rhb_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             squash_valid,
    input logic             busy,
    input logic             full,
    input logic             empty,
    input logic             restore_valid,
    input logic             release_valid,
    input logic [CNT_W-1:0] committed_maps,
    input logic [CNT_W-1:0] undone_maps
);
    // R1: a reset edge leaves the buffer empty and idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !busy));

    // R2: a full buffer stays full until something is removed.
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !release_valid) |=> full);

    // R6: during a squash request or undo walk, any release is an undo.
    a_r6_squash_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((squash_valid || busy) && release_valid) |-> restore_valid);

    // R7: every commit removal advances the commit counter by one.
    a_r7_commit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (release_valid && !restore_valid) |=>
            (committed_maps == CNT_W'($past(committed_maps) + CNT_W'(1))));

    // R7: every undo advances the undo counter by one.
    a_r7_undo_step: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |=> (undone_maps == CNT_W'($past(undone_maps) + CNT_W'(1))));

    // R9: empty and full never hold together.
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R3: an empty buffer drives no map or free-list writes.
    a_r3_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!restore_valid && !release_valid));

endmodule

bind rename_history_buf rhb_checker #(.CNT_W(CNT_W)) u_rhb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .squash_valid  (squash_valid),
    .busy          (busy),
    .full          (full),
    .empty         (empty),
    .restore_valid (restore_valid),
    .release_valid (release_valid),
    .committed_maps(committed_maps),
    .undone_maps   (undone_maps)
);

// File: tb/rename_history_buf_tb.sv
// Bench: sweeps every fill level against every squash point, then commits
// survivors; adds a squash/commit priority case and a push-during-squash case.
module rename_history_buf_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH  = 8;
    localparam int SEQ_W  = 8;
    localparam int AREG_W = 5;
    localparam int PREG_W = 6;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_valid = 1'b0;
    logic [SEQ_W-1:0]  push_seq = '0;
    logic [AREG_W-1:0] push_areg = '0;
    logic [PREG_W-1:0] push_new_preg = '0;
    logic [PREG_W-1:0] push_old_preg = '0;
    logic              commit_valid = 1'b0;
    logic [SEQ_W-1:0]  commit_seq = '0;
    logic              squash_valid = 1'b0;
    logic [SEQ_W-1:0]  squash_seq = '0;
    logic              restore_valid;
    logic [AREG_W-1:0] restore_areg;
    logic [PREG_W-1:0] restore_preg;
    logic              release_valid;
    logic [PREG_W-1:0] release_preg;
    logic              busy;
    logic              full;
    logic              empty;
    logic [CNT_W-1:0]  committed_maps;
    logic [CNT_W-1:0]  undone_maps;

    int checks = 0;
    int errors = 0;
    int n_com  = 0;
    int n_undo = 0;
    logic [SEQ_W-1:0] next_seq = 8'd200;

    logic [SEQ_W-1:0] q_seq [$];
    logic [PREG_W-1:0] q_np [$];
    logic [PREG_W-1:0] q_op [$];

    always #4 clk = !clk;

    rename_history_buf #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
        .PREG_W(PREG_W), .CNT_W(CNT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_seq(push_seq), .push_areg(push_areg),
        .push_new_preg(push_new_preg), .push_old_preg(push_old_preg),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .restore_valid(restore_valid), .restore_areg(restore_areg),
        .restore_preg(restore_preg), .release_valid(release_valid),
        .release_preg(release_preg), .busy(busy), .full(full), .empty(empty),
        .committed_maps(committed_maps), .undone_maps(undone_maps)
    );

    function automatic bit younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        int d;
        d = (int'(a) - int'(b) + 256) % 256;
        return (d >= 1) && (d <= 127);
    endfunction

    function automatic logic [AREG_W-1:0] f_areg(input logic [SEQ_W-1:0] s);
        return AREG_W'(s % 32);
    endfunction
    function automatic logic [PREG_W-1:0] f_newp(input logic [SEQ_W-1:0] s);
        return PREG_W'((int'(s) * 3 + 1) % 64);
    endfunction
    function automatic logic [PREG_W-1:0] f_oldp(input logic [SEQ_W-1:0] s);
        return PREG_W'((int'(s) * 5 + 7) % 64);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " committed_maps (R7)"}, int'(committed_maps), n_com);
        chk({tag, " undone_maps (R7)"}, int'(undone_maps), n_undo);
    endtask

    // Offer one push; the model stores it only if not full (R2).
    task automatic do_push(input logic [SEQ_W-1:0] s);
        @(negedge clk);
        push_valid = 1'b1;
        push_seq = s;
        push_areg = f_areg(s);
        push_new_preg = f_newp(s);
        push_old_preg = f_oldp(s);
        #2;
        chk("R2 full flag before push", int'(full), int'(q_seq.size() == DEPTH));
        @(posedge clk);
        if (q_seq.size() < DEPTH) begin
            q_seq.push_back(s);
            q_np.push_back(f_newp(s));
            q_op.push_back(f_oldp(s));
        end
        #1 push_valid = 1'b0;
    endtask

    // Undo walk from the current sample point (R3, R4, R10).
    task automatic undo_walk(input logic [SEQ_W-1:0] bound);
        for (int i = 0; i < DEPTH + 2; i++) begin
            bit exp_undo;
            exp_undo = (q_seq.size() > 0) && younger(q_seq[$], bound);
            chk("R4 busy", int'(busy), int'(exp_undo));
            if (!exp_undo) begin
                chk("R4 walk stops, restore_valid", int'(restore_valid), 0);
                break;
            end
            chk("R3 restore_valid", int'(restore_valid), 1);
            chk("R3 restore_areg", int'(restore_areg), int'(f_areg(q_seq[$])));
            chk("R3 restore_preg", int'(restore_preg), int'(q_op[$]));
            chk("R3 release_valid", int'(release_valid), 1);
            chk("R3 R10 release_preg new", int'(release_preg), int'(q_np[$]));
            void'(q_seq.pop_back());
            void'(q_np.pop_back());
            void'(q_op.pop_back());
            n_undo++;
            @(negedge clk);
            #2;
        end
    endtask

    // Commit walk from the current sample point (R5, R10).
    task automatic retire_walk(input logic [SEQ_W-1:0] bound);
        for (int i = 0; i < DEPTH + 2; i++) begin
            bit exp_pop;
            exp_pop = (q_seq.size() > 0) && !younger(q_seq[0], bound);
            if (!exp_pop) begin
                chk("R5 commit walk stops, release_valid", int'(release_valid), 0);
                break;
            end
            chk("R5 release_valid", int'(release_valid), 1);
            chk("R5 restore_valid low", int'(restore_valid), 0);
            chk("R5 R10 release_preg old", int'(release_preg), int'(q_op[0]));
            void'(q_seq.pop_front());
            void'(q_np.pop_front());
            void'(q_op.pop_front());
            n_com++;
            @(negedge clk);
            #2;
        end
    endtask

    task automatic issue_squash(input logic [SEQ_W-1:0] bound);
        @(negedge clk);
        squash_valid = 1'b1;
        squash_seq = bound;
        #2;
        chk("R6 no release in squash cycle", int'(release_valid), 0);
        @(posedge clk);
        #1 squash_valid = 1'b0;
        @(negedge clk);
        #2;
        undo_walk(bound);
    endtask

    task automatic issue_commit(input logic [SEQ_W-1:0] bound);
        @(negedge clk);
        commit_valid = 1'b1;
        commit_seq = bound;
        @(posedge clk);
        #1 commit_valid = 1'b0;
        @(negedge clk);
        #2;
        retire_walk(bound);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 restore_valid", int'(restore_valid), 0);
        chk("R1 release_valid", int'(release_valid), 0);
        chk_counts("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: fill 0..DEPTH entries, squash keeping k, commit survivors.
        for (int fill = 0; fill <= DEPTH; fill++) begin
            for (int k = 0; k <= fill; k++) begin
                logic [SEQ_W-1:0] base;
                base = next_seq;
                for (int e = 0; e < fill; e++) do_push(SEQ_W'(base + e));
                if (fill == DEPTH && k == 0) begin
                    do_push(SEQ_W'(base + fill));
                    chk("R2 extra push ignored, full", int'(full), 1);
                end
                issue_squash(SEQ_W'(base + k - 1));
                chk("R4 survivors kept", int'(q_seq.size()), k);
                chk("R9 empty after squash", int'(empty), int'(k == 0));
                next_seq = SEQ_W'(base + k);
                issue_commit(SEQ_W'(base + k - 1));
                chk("R9 empty after commit", int'(empty), 1);
                chk_counts("sweep");
            end
        end

        // Priority: squash and commit in the same cycle (R6).
        begin
            logic [SEQ_W-1:0] s0;
            s0 = next_seq;
            for (int e = 0; e < 3; e++) do_push(SEQ_W'(s0 + e));
            @(negedge clk);
            squash_valid = 1'b1;
            squash_seq = SEQ_W'(s0 + 1);
            commit_valid = 1'b1;
            commit_seq = s0;
            #2;
            chk("R6 no commit release with squash", int'(release_valid), 0);
            @(posedge clk);
            #1;
            squash_valid = 1'b0;
            commit_valid = 1'b0;
            @(negedge clk);
            #2;
            undo_walk(SEQ_W'(s0 + 1));
            retire_walk(s0);
            chk("R6 one entry left", int'(q_seq.size()), 1);
            issue_commit(SEQ_W'(s0 + 1));
            chk("R9 empty after priority case", int'(empty), 1);
            chk_counts("R6");
            next_seq = SEQ_W'(s0 + 2);
        end

        // Pushes during the squash cycle and the walk are dropped (R8).
        begin
            logic [SEQ_W-1:0] t0;
            t0 = next_seq;
            do_push(t0);
            do_push(SEQ_W'(t0 + 1));
            @(negedge clk);
            squash_valid = 1'b1;
            squash_seq = SEQ_W'(t0 - 1);
            push_valid = 1'b1;
            push_seq = SEQ_W'(t0 + 2);
            push_areg = f_areg(SEQ_W'(t0 + 2));
            push_new_preg = f_newp(SEQ_W'(t0 + 2));
            push_old_preg = f_oldp(SEQ_W'(t0 + 2));
            @(posedge clk);
            #1 squash_valid = 1'b0;
            @(negedge clk);
            #2;
            chk("R8 busy while push offered", int'(busy), 1);
            chk("R8 undo youngest real entry", int'(restore_preg), int'(q_op[$]));
            chk("R8 release new preg", int'(release_preg), int'(q_np[$]));
            void'(q_seq.pop_back());
            void'(q_np.pop_back());
            void'(q_op.pop_back());
            n_undo++;
            @(negedge clk);
            push_valid = 1'b0;
            #2;
            undo_walk(SEQ_W'(t0 - 1));
            chk("R8 R9 empty, pushes dropped", int'(empty), 1);
            chk_counts("R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule